// File: doc/BRIEF.md
# Bus Match Trap Generator

This block is a debug comparator that sits on a CPU bus and looks at every bus cycle. It compares the 16-bit address, the 8-bit data value and a 2-bit control field against programmed patterns. When the whole pattern matches, it raises the CPU's non-maskable interrupt request. Each of the three fields has a compare register and a qualifier register. A qualifier bit of 1 makes the matching bus bit take part in the comparison, and a qualifier bit of 0 makes that bit a don't-care.

Software programs the block through an eight-byte register window. The window is selected by an externally decoded chip select, and the offset comes from the low three address bits. The interrupt request is latched when a match occurs and stays high until software writes any of the window registers. This guarantees that the CPU always sees a clean edge.

The sequencing is held in a three-state machine:
- **ST_OFF**: the trap is disabled.
- **ST_ARMED**: the trap is enabled and waiting for a match.
- **ST_HELD**: the interrupt request is asserted.

The transitions between the states are:
- **ARM**: a window write that leaves the enable bit at 1. It goes from any state to ST_ARMED.
- **DISARM**: a window write that leaves the enable bit at 0. It goes from any state to ST_OFF.
- **FIRE**: a full match in a non-window cycle while in ST_ARMED. It goes to ST_HELD.
- **RELEASE**: any window write while in ST_HELD. It leaves ST_HELD for ST_ARMED or ST_OFF, depending on the enable bit.
- **STAY**: every other cycle. The state does not change.

Top module: `bus_trap_unit`

## Requirements
- R1: After reset, `nmi_req` is low and all eight window offsets read 0x00.
- R2: A window write happens in a cycle where `trap_cs`=1, `cpu_vma`=1 and `cpu_rw`=0. It stores `cpu_data` at offset `cpu_addr[2:0]`. `reg_rdata` shows the register at `cpu_addr[2:0]` in the same cycle while `trap_cs`=1, and shows 0x00 while `trap_cs`=0. The window layout is:
  - offset 0: address compare, high byte
  - offset 1: address compare, low byte
  - offset 2: data compare
  - offset 3: control compare. Bit 7 is the enable bit and bits 1:0 are the control pattern. Bits 6:2 read 0.
  - offset 4: address qualifier, high byte
  - offset 5: address qualifier, low byte
  - offset 6: data qualifier
  - offset 7: control qualifier. Bits 1:0 are used and bits 7:2 read 0.
- R3: A field matches when ((bus XOR compare) AND qualifier) is zero. A qualifier bit of 0 excludes that bit from the comparison.
- R4: The trap needs the address, data and control fields to match in the same cycle. The control field has bit 1 = `cpu_rw` and bit 0 = `cpu_vma`.
- R5: While the enable bit (offset 3, bit 7) is 0, `nmi_req` never rises, even when every qualifier is zero.
- R6: A matching cycle at clock edge N drives `nmi_req` high from edge N onward, which means it is visible in the following cycle.
- R7: Once high, `nmi_req` stays high through any later cycles, matching or not, until a window write. After the edge of that write, `nmi_req` is low.
- R8: A cycle with `trap_cs`=1 never causes a trap, even if its bus values match.
- R9: After a write releases the request with the enable bit still 1, the next full match raises `nmi_req` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Bus address of the current cycle |
| cpu_data | input | 8 | Bus data value of the current cycle (also the window write data) |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_vma | input | 1 | Valid memory access qualifier |
| trap_cs | input | 1 | Register window select, decoded outside |
| reg_rdata | output | 8 | Window read data (0x00 when not selected) |
| nmi_req | output | 1 | Latched non-maskable interrupt request |

## Verification
The bench sets all qualifiers to zero with the enable bit set. This catches a design that ignores the enable bit or gates it wrongly: such a design would trap on every cycle, or never. It then masks single address nibbles and the control bits to expose a swapped qualifier polarity or a control field in the wrong bit order, either of which makes matches appear or vanish. It drives matching values during window accesses to catch a design that traps on its own register traffic. It also keeps driving matching cycles while the request is held, then writes a register, to show a request that is dropped too early or never released. Random bus cycles, with values biased toward the programmed pattern, are compared cycle by cycle against a model of the match and the latch.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int CTRL_W = 2;
    localparam int NUM_REGS = 8;
    localparam int OFS_W = $clog2(NUM_REGS);
    localparam int EN_BIT = BYTE_W - 1;

    localparam logic [OFS_W-1:0] OFS_ACMP_HI = 3'd0;
    localparam logic [OFS_W-1:0] OFS_ACMP_LO = 3'd1;
    localparam logic [OFS_W-1:0] OFS_DCMP    = 3'd2;
    localparam logic [OFS_W-1:0] OFS_CCMP    = 3'd3;
    localparam logic [OFS_W-1:0] OFS_AQ_HI   = 3'd4;
    localparam logic [OFS_W-1:0] OFS_AQ_LO   = 3'd5;
    localparam logic [OFS_W-1:0] OFS_DQ      = 3'd6;
    localparam logic [OFS_W-1:0] OFS_CQ      = 3'd7;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } trap_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
        logic [CTRL_W-1:0] ctrl;
    } trap_pattern_t;
endpackage

// File: rtl/trap_field_cmp.sv
module trap_field_cmp #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bus_val,
    input  logic [WIDTH-1:0] cmp_val,
    input  logic [WIDTH-1:0] qual_val,
    output logic             hit
);
    logic [WIDTH-1:0] diff_bits;

    always_comb begin
        diff_bits = (bus_val ^ cmp_val) & qual_val;
        hit = ~|diff_bits;
    end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_sel,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output trap_pattern_t     cmp_pat,
    output trap_pattern_t     qual_pat,
    output logic              trap_en,
    output logic              en_after
);
    localparam int HALF_A = ADDR_W / 2;

    logic [BYTE_W-1:0] reg_q [NUM_REGS];
    logic [BYTE_W-1:0] keep_mask [NUM_REGS];
    logic [BYTE_W-1:0] rd_mux;

    // Bits not implemented in a register are forced to zero on write.
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_mask
            if (g == int'(OFS_CCMP)) begin : g_ccmp
                assign keep_mask[g] = BYTE_W'((1 << EN_BIT) | ((1 << CTRL_W) - 1));
            end else if (g == int'(OFS_CQ)) begin : g_cq
                assign keep_mask[g] = BYTE_W'((1 << CTRL_W) - 1);
            end else begin : g_full
                assign keep_mask[g] = {BYTE_W{1'b1}};
            end
        end
    endgenerate

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    reg_q[g] <= '0;
                end else if (wr_stb && (ofs == OFS_W'(g))) begin
                    reg_q[g] <= wdata & keep_mask[g];
                end
            end
        end
    endgenerate

    always_comb begin
        rd_mux = reg_q[ofs];
        rdata = rd_sel ? rd_mux : '0;
    end

    always_comb begin
        cmp_pat.addr = {reg_q[OFS_ACMP_HI][HALF_A-1:0], reg_q[OFS_ACMP_LO][HALF_A-1:0]};
        cmp_pat.data = reg_q[OFS_DCMP];
        cmp_pat.ctrl = reg_q[OFS_CCMP][CTRL_W-1:0];
        qual_pat.addr = {reg_q[OFS_AQ_HI][HALF_A-1:0], reg_q[OFS_AQ_LO][HALF_A-1:0]};
        qual_pat.data = reg_q[OFS_DQ];
        qual_pat.ctrl = reg_q[OFS_CQ][CTRL_W-1:0];
        trap_en = reg_q[OFS_CCMP][EN_BIT];
    end

    // Enable value that will be in force after this cycle's write.
    always_comb begin
        if (wr_stb && (ofs == OFS_CCMP)) begin
            en_after = wdata[EN_BIT];
        end else begin
            en_after = trap_en;
        end
    end
endmodule

// File: rtl/trap_ctrl_fsm.sv
module trap_ctrl_fsm
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic en_after,
    input  logic cycle_hit,
    output logic nmi_out
);
    trap_state_t state_q;
    trap_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_stb) begin
            // ARM / DISARM / RELEASE
            state_d = en_after ? ST_ARMED : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_OFF;
                ST_ARMED: state_d = cycle_hit ? ST_HELD : ST_ARMED;
                ST_HELD:  state_d = ST_HELD;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_OFF:   nmi_out = 1'b0;
            ST_ARMED: nmi_out = 1'b0;
            ST_HELD:  nmi_out = 1'b1;
            default:  nmi_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/bus_trap_unit.sv
module bus_trap_unit
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_vma,
    input  logic              trap_cs,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              nmi_req
);
    localparam int NUM_FIELDS = 3;

    trap_pattern_t   bus_pat;
    trap_pattern_t   cmp_pat;
    trap_pattern_t   qual_pat;
    logic            reg_we;
    logic            trap_en;
    logic            en_after;
    logic [NUM_FIELDS-1:0] field_hit;
    logic            all_hit;
    logic            cycle_hit;

    assign reg_we = trap_cs & cpu_vma & ~cpu_rw;

    always_comb begin
        bus_pat.addr = cpu_addr;
        bus_pat.data = cpu_data;
        bus_pat.ctrl = {cpu_rw, cpu_vma};
    end

    trap_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (reg_we),
        .rd_sel   (trap_cs),
        .ofs      (cpu_addr[OFS_W-1:0]),
        .wdata    (cpu_data),
        .rdata    (reg_rdata),
        .cmp_pat  (cmp_pat),
        .qual_pat (qual_pat),
        .trap_en  (trap_en),
        .en_after (en_after)
    );

    trap_field_cmp #(.WIDTH(ADDR_W)) u_cmp_addr (
        .bus_val  (bus_pat.addr),
        .cmp_val  (cmp_pat.addr),
        .qual_val (qual_pat.addr),
        .hit      (field_hit[0])
    );

    trap_field_cmp #(.WIDTH(BYTE_W)) u_cmp_data (
        .bus_val  (bus_pat.data),
        .cmp_val  (cmp_pat.data),
        .qual_val (qual_pat.data),
        .hit      (field_hit[1])
    );

    trap_field_cmp #(.WIDTH(CTRL_W)) u_cmp_ctrl (
        .bus_val  (bus_pat.ctrl),
        .cmp_val  (cmp_pat.ctrl),
        .qual_val (qual_pat.ctrl),
        .hit      (field_hit[2])
    );

    assign all_hit = &field_hit;
    assign cycle_hit = all_hit & ~trap_cs;

    trap_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (reg_we),
        .en_after  (en_after),
        .cycle_hit (cycle_hit),
        .nmi_out   (nmi_req)
    );
endmodule

// File: rtl/bus_trap_chk.sv
module bus_trap_chk (
    input logic clk,
    input logic rst_n,
    input logic trap_cs,
    input logic reg_we,
    input logic trap_en,
    input logic all_hit,
    input logic nmi_req
);
    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !nmi_req); // R7

    AST_HOLD_UNTIL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !reg_we) |=> nmi_req); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_en |=> !nmi_req); // R5

    AST_MATCH_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_en && !trap_cs && all_hit) |=> nmi_req); // R6

    AST_RISE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> $past(all_hit && !trap_cs && trap_en)); // R8
endmodule

bind bus_trap_unit bus_trap_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .trap_cs (trap_cs),
    .reg_we  (reg_we),
    .trap_en (trap_en),
    .all_hit (all_hit),
    .nmi_req (nmi_req)
);

// File: tb/test_bus_trap_unit.sv
module test_bus_trap_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_rw = 1'b1;
    logic        cpu_vma = 1'b0;
    logic        trap_cs = 1'b0;
    logic [7:0]  reg_rdata;
    logic        nmi_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_reg [8];
    bit         m_held = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_trap_unit i_bus_trap_unit (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_vma(cpu_vma), .trap_cs(trap_cs),
        .reg_rdata(reg_rdata), .nmi_req(nmi_req)
    );

    function automatic bit exp_match(logic [15:0] a, logic [7:0] d, logic rw, logic vma);
        logic [15:0] ac = {m_reg[0], m_reg[1]};
        logic [15:0] aq = {m_reg[4], m_reg[5]};
        logic [1:0]  ctl = {rw, vma};
        return (((a ^ ac) & aq) == 16'h0) && (((d ^ m_reg[2]) & m_reg[6]) == 8'h0)
            && (((ctl ^ m_reg[3][1:0]) & m_reg[7][1:0]) == 2'b0);
    endfunction

    function automatic logic [7:0] keep_bits(int ofs, logic [7:0] d);
        if (ofs == 3) return d & 8'h83;
        if (ofs == 7) return d & 8'h03;
        return d;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic [15:0] a, logic [7:0] d, logic rw, logic vma, logic cs, string tag);
        logic [7:0] exp_rd;
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = rw; cpu_vma = vma; trap_cs = cs;
        #1;
        exp_rd = cs ? m_reg[a[2:0]] : 8'h00;
        chk(reg_rdata == exp_rd, {tag, " R2 readback"}, reg_rdata, exp_rd);
        if (cs && vma && !rw) begin
            m_reg[a[2:0]] = keep_bits(int'(a[2:0]), d);
            m_held = 0;
        end else if (!m_held && m_reg[3][7] && !cs && exp_match(a, d, rw, vma)) begin
            m_held = 1;
        end
        @(posedge clk);
        #1;
        chk(nmi_req == m_held, {tag, " nmi"}, nmi_req, m_held);
    endtask

    task automatic wr(int ofs, logic [7:0] d, string tag);
        cyc(16'h9000 | 16'(ofs), d, 1'b0, 1'b1, 1'b1, tag);
    endtask

    task automatic idle(logic [15:0] a, logic [7:0] d, logic rw, logic vma, string tag);
        cyc(a, d, rw, vma, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk(nmi_req == 1'b0, "R1 nmi after reset", nmi_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) cyc(16'h9000 | 16'(i), 8'h00, 1'b1, 1'b1, 1'b1, "R1");

        // R5: enable with all qualifiers zero fires on the next plain cycle
        idle(16'h0000, 8'h00, 1'b1, 1'b1, "R5 disabled");
        wr(3, 8'h80, "R6 arm");
        idle(16'hABCD, 8'h11, 1'b1, 1'b0, "R6 fire");
        idle(16'h0000, 8'h00, 1'b1, 1'b1, "R7 hold");
        wr(3, 8'hFF, "R2 unused bits");
        cyc(16'h9003, 8'h00, 1'b1, 1'b1, 1'b1, "R2 ofs3");
        wr(7, 8'hFF, "R2 cq");
        cyc(16'h9007, 8'h00, 1'b1, 1'b1, 1'b1, "R2 ofs7");
        wr(7, 8'h00, "R2 cq clear");
        wr(3, 8'h00, "R5 disarm");
        for (int i = 0; i < 4; i++) idle(16'(i * 7), 8'h00, 1'b1, 1'b1, "R5 off");

        // R3: address compare with full mask and partial mask
        wr(0, 8'h12, "R2"); wr(1, 8'h34, "R2");
        wr(4, 8'hFF, "R2"); wr(5, 8'hFF, "R2");
        wr(3, 8'h80, "R3 arm");
        idle(16'h1235, 8'h00, 1'b1, 1'b1, "R3 miss");
        idle(16'h1234, 8'h00, 1'b1, 1'b1, "R3 hit");
        idle(16'h0000, 8'h00, 1'b0, 1'b1, "R7 hold1");
        idle(16'hFFFF, 8'h00, 1'b1, 1'b0, "R7 hold2");
        wr(5, 8'h00, "R7 release");
        idle(16'h12AB, 8'h00, 1'b1, 1'b1, "R3 masked low byte");
        idle(16'h1334, 8'h00, 1'b1, 1'b1, "R7 held on");

        // R4: data and control fields
        wr(2, 8'h5A, "R9 release keep enable");
        wr(6, 8'hFF, "R4");
        idle(16'h1200, 8'h5B, 1'b1, 1'b1, "R4 data miss");
        idle(16'h1200, 8'h5A, 1'b1, 1'b1, "R9 refire");
        wr(3, 8'h81, "R4 ctrl pattern");
        wr(7, 8'h03, "R4 ctrl mask");
        idle(16'h1200, 8'h5A, 1'b1, 1'b1, "R4 read no match");
        idle(16'h1200, 8'h5A, 1'b0, 1'b0, "R4 vma low no match");
        idle(16'h1200, 8'h5A, 1'b0, 1'b1, "R4 write match");

        // R8: window cycles with matching values never trap
        for (int i = 0; i < 8; i++) wr(i, 8'h00, "R8 clear");
        wr(3, 8'h80, "R8 arm");
        for (int i = 0; i < 8; i++) cyc(16'h9000 | 16'(i), 8'h00, 1'b1, 1'b1, 1'b1, "R8 window read");
        idle(16'h4444, 8'h44, 1'b1, 1'b1, "R8 plain cycle fires");

        // Random phase
        void'($urandom(32'h5EED1234));
        for (int blk = 0; blk < 60; blk++) begin
            for (int i = 0; i < 8; i++) begin
                logic [7:0] v = 8'($urandom);
                if (i >= 4) v = v & 8'($urandom) & 8'($urandom);
                if (i == 3) v = ($urandom % 4 != 0) ? (v | 8'h80) : (v & 8'h7F);
                wr(i, v, "R3 rnd prog");
            end
            for (int k = 0; k < 30; k++) begin
                logic [15:0] a = 16'($urandom);
                logic [7:0]  d = 8'($urandom);
                logic        rw = 1'($urandom);
                logic        vm = 1'($urandom);
                logic        cs = ($urandom % 16 == 0);
                if ($urandom % 2 == 0) begin
                    a = {m_reg[0], m_reg[1]} ^ (a & ~{m_reg[4], m_reg[5]});
                    d = m_reg[2] ^ (d & ~m_reg[6]);
                end
                cyc(a, d, rw, vm, cs, "R4 rnd");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule